// File: doc/BRIEF.md
# Interrupt Priority and Vector Resolver

This block looks at every pending interrupt request in a cycle and picks one to service. It then reports the winner's source number and the vector address the processor fetches its handler from. Three non-maskable sources rank above everything else. These are an illegal-instruction trap, a software trap and an external high-priority pin. Nineteen maskable sources follow them, and they are served only while the global mask input is low. Maskable source 0 is the plain external interrupt pin and needs no enable. Every other maskable source also needs its own enable bit.

Maskable sources are ranked by a fixed default order, where a lower index wins. A promotion register names one maskable source that is lifted above all the others. Software may rewrite the promotion register only while the global mask is set. The high-priority pin has a sticky mask. Software can set it, and only reset clears it. Results are registered, so outputs follow the inputs sampled at the previous clock edge.

A resolver state machine holds one of three states. ST_IDLE means nothing is to be served. ST_NMI means a non-maskable source won. ST_MASK means a maskable source won. On every edge it moves from any state to ST_NMI if a non-maskable request is eligible. Otherwise it moves to ST_MASK if a maskable request is eligible, and to ST_IDLE if neither is. A second machine tracks the pin mask. It has two states, XM_OPEN and XM_SHUT. It moves from XM_OPEN to XM_SHUT on a set pulse and never returns to XM_OPEN except through reset.

Top module: `irq_resolver`

## Requirements
- R1: After reset, irq_out is 0, win_id is 0 and win_vec is 0. The promotion register selects maskable source 0 and the pin mask is open.
- R2: Outputs reflect the inputs sampled at the previous rising edge. When no source is eligible, irq_out is 0 and win_id and win_vec are both 0.
- R3: Non-maskable sources win over any maskable source regardless of gmask. Among them the illegal trap (win_id 0) ranks above the software trap (win_id 1), which ranks above the pin (win_id 2).
- R4: A pulse on xmask_set blocks xpin_req from the following cycle onward. The block stays in force until reset.
- R5: No maskable source is served while gmask is 1.
- R6: Maskable source 0 needs no enable. Maskable source k>0 is eligible only when msk_en[k] is 1.
- R7: Among eligible maskable sources that are not promoted, the lowest index wins.
- R8: If the promoted source is eligible, it wins over all other maskable sources. If it is not eligible, the default order applies.
- R9: A write on prio_we updates the promotion register only when gmask is 1 and prio_wdata is below 19. Otherwise the write is ignored. A write affects arbitration from the next cycle.
- R10: Maskable source k is reported as win_id k+3.
- R11: Vectors are as follows. win_id 0/1/2 map to 0xFFF8/0xFFF6/0xFFF4. Maskable source k<14 maps to 0xFFF2-2k. Sources 14 to 18 share 0xFFD6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| illop_req | input | 1 | Illegal-instruction trap request |
| swi_req | input | 1 | Software trap request |
| xpin_req | input | 1 | High-priority external pin request |
| xmask_set | input | 1 | Sets the sticky pin mask |
| msk_req | input | 19 | Maskable requests, bit 0 is the external interrupt pin |
| msk_en | input | 19 | Local enables, bit 0 unused |
| gmask | input | 1 | Global mask for maskable sources |
| prio_we | input | 1 | Promotion register write strobe |
| prio_wdata | input | 5 | Index of the source to promote |
| irq_out | output | 1 | A source is being requested |
| win_id | output | 5 | Winning source number |
| win_vec | output | 16 | Vector address of the winner |

## Verification
The assertions assume that requests and enables are synchronous levels that settle before each rising edge. They also assume that a promotion write carries meaningful data only during the cycle its strobe is high. The bench changes every input just after a falling edge and holds it for one full cycle, so each expected result lines up with exactly one sampled edge. Promotion writes are issued with gmask set and cleared, and with in-range and out-of-range indices. The effect of each write is then read back through later arbitration rather than from the register.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NMI  = 2'd1,
        ST_MASK = 2'd2
    } res_state_t;

    typedef enum logic {
        XM_OPEN = 1'b0,
        XM_SHUT = 1'b1
    } xm_state_t;

    localparam int NUM_NMI = 3;

endpackage

// File: rtl/irq_xmask_fsm.sv
module irq_xmask_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic shut_o
);

    xm_state_t xm_q, xm_d;

    always_comb begin
        xm_d = xm_q;
        unique case (xm_q)
            XM_OPEN: if (set_i) xm_d = XM_SHUT;
            XM_SHUT: xm_d = XM_SHUT;
            default: xm_d = XM_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xm_q <= XM_OPEN;
        else        xm_q <= xm_d;
    end

    assign shut_o = (xm_q == XM_SHUT);

endmodule

// File: rtl/irq_promo_reg.sv
module irq_promo_reg #(
    parameter int NMSK = 19,
    parameter int PW   = $clog2(NMSK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          gmask_i,
    input  logic [PW-1:0] wdata_i,
    output logic [PW-1:0] promo_o
);

    localparam logic [PW-1:0] LIMIT = PW'(NMSK);

    logic accept;
    assign accept = we_i && gmask_i && (wdata_i < LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n)      promo_o <= '0;
        else if (accept) promo_o <= wdata_i;
    end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
    parameter int NMSK = 19,
    parameter int PW   = $clog2(NMSK)
) (
    input  logic [NMSK-1:0] req_i,
    input  logic [NMSK-1:0] en_i,
    input  logic            gmask_i,
    input  logic [PW-1:0]   promo_i,
    output logic            any_o,
    output logic [PW-1:0]   idx_o
);

    logic [NMSK-1:0] elig;
    logic [PW-1:0]   dflt_idx;
    logic            promo_hit;

    // Source 0 is the external pin and carries no local enable.
    assign elig = req_i & {en_i[NMSK-1:1], 1'b1} & {NMSK{~gmask_i}};

    always_comb begin
        dflt_idx  = '0;
        promo_hit = 1'b0;
        for (int i = NMSK - 1; i >= 0; i--) begin
            if (elig[i]) dflt_idx = PW'(i);
        end
        for (int i = 0; i < NMSK; i++) begin
            if (elig[i] && (promo_i == PW'(i))) promo_hit = 1'b1;
        end
    end

    assign any_o = |elig;
    assign idx_o = promo_hit ? promo_i : dflt_idx;

endmodule

// File: rtl/irq_vector_map.sv
module irq_vector_map #(
    parameter int          NMSK         = 19,
    parameter int          SHARED_FIRST = 14,
    parameter int          IDW          = 5,
    parameter logic [15:0] VEC_HI       = 16'hFFF8
) (
    input  logic            valid_i,
    input  logic [IDW-1:0]  id_i,
    output logic [15:0]     vec_o
);

    localparam int          NNMI    = irq_pkg::NUM_NMI;
    localparam logic [15:0] MSK_TOP = VEC_HI - 16'(2 * NNMI);

    logic [15:0] grp;

    always_comb begin
        grp   = 16'(id_i) - 16'(NNMI);
        if (grp > 16'(SHARED_FIRST)) grp = 16'(SHARED_FIRST);
        vec_o = '0;
        if (valid_i) begin
            if (id_i < IDW'(NNMI)) vec_o = VEC_HI - 16'({id_i, 1'b0});
            else                   vec_o = MSK_TOP - {grp[14:0], 1'b0};
        end
    end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_pkg::*;
#(
    parameter int          NMSK         = 19,
    parameter int          SHARED_FIRST = 14,
    parameter logic [15:0] VEC_HI       = 16'hFFF8,
    parameter int          PW           = $clog2(NMSK),
    parameter int          IDW          = $clog2(NMSK + NUM_NMI)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            illop_req,
    input  logic            swi_req,
    input  logic            xpin_req,
    input  logic            xmask_set,
    input  logic [NMSK-1:0] msk_req,
    input  logic [NMSK-1:0] msk_en,
    input  logic            gmask,
    input  logic            prio_we,
    input  logic [PW-1:0]   prio_wdata,
    output logic            irq_out,
    output logic [IDW-1:0]  win_id,
    output logic [15:0]     win_vec
);

    res_state_t      state_q, state_d;
    logic            xm_shut;
    logic [PW-1:0]   promo_q;
    logic            msk_any;
    logic [PW-1:0]   msk_idx;
    logic            nmi_any;
    logic [IDW-1:0]  nmi_id;
    logic [IDW-1:0]  id_q;

    irq_xmask_fsm u_xmask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (xmask_set),
        .shut_o (xm_shut)
    );

    irq_promo_reg #(.NMSK(NMSK), .PW(PW)) u_promo (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (prio_we),
        .gmask_i (gmask),
        .wdata_i (prio_wdata),
        .promo_o (promo_q)
    );

    irq_select #(.NMSK(NMSK), .PW(PW)) u_sel (
        .req_i   (msk_req),
        .en_i    (msk_en),
        .gmask_i (gmask),
        .promo_i (promo_q),
        .any_o   (msk_any),
        .idx_o   (msk_idx)
    );

    always_comb begin
        nmi_any = illop_req | swi_req | (xpin_req & ~xm_shut);
        if (illop_req)    nmi_id = IDW'(0);
        else if (swi_req) nmi_id = IDW'(1);
        else              nmi_id = IDW'(2);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_NMI, ST_MASK: begin
                if (nmi_any)      state_d = ST_NMI;
                else if (msk_any) state_d = ST_MASK;
                else              state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else begin
            unique case (state_d)
                ST_NMI:  id_q <= nmi_id;
                ST_MASK: id_q <= IDW'(msk_idx) + IDW'(NUM_NMI);
                default: id_q <= '0;
            endcase
        end
    end

    assign irq_out = (state_q != ST_IDLE);
    assign win_id  = id_q;

    irq_vector_map #(
        .NMSK(NMSK), .SHARED_FIRST(SHARED_FIRST), .IDW(IDW), .VEC_HI(VEC_HI)
    ) u_vmap (
        .valid_i (irq_out),
        .id_i    (id_q),
        .vec_o   (win_vec)
    );

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
    parameter int          NMSK         = 19,
    parameter int          SHARED_FIRST = 14,
    parameter logic [15:0] VEC_HI       = 16'hFFF8,
    parameter int          PW           = 5,
    parameter int          IDW          = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            illop_req,
    input logic            swi_req,
    input logic            xpin_req,
    input logic            gmask,
    input logic            prio_we,
    input logic [PW-1:0]   prio_wdata,
    input logic            irq_out,
    input logic [IDW-1:0]  win_id,
    input logic [15:0]     win_vec,
    input logic [PW-1:0]   promo_q,
    input logic            xm_shut
);

    localparam logic [15:0] VEC_LO = VEC_HI - 16'(6 + 2 * SHARED_FIRST);

    p_illop_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        illop_req |=> (irq_out && win_id == '0));

    p_mask_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && !illop_req && !swi_req && !(xpin_req && !xm_shut)) |=> !irq_out);

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> (win_id == '0 && win_vec == '0));

    p_xmask_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xm_shut |=> xm_shut);

    p_promo_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_we && (!gmask || prio_wdata >= PW'(NMSK))) |=> $stable(promo_q));

    p_promo_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        promo_q < PW'(NMSK));

    p_vec_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (!win_vec[0] && win_vec >= VEC_LO && win_vec <= VEC_HI));

endmodule

bind irq_resolver irq_resolver_chk #(
    .NMSK(NMSK), .SHARED_FIRST(SHARED_FIRST), .VEC_HI(VEC_HI), .PW(PW), .IDW(IDW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .illop_req  (illop_req),
    .swi_req    (swi_req),
    .xpin_req   (xpin_req),
    .gmask      (gmask),
    .prio_we    (prio_we),
    .prio_wdata (prio_wdata),
    .irq_out    (irq_out),
    .win_id     (win_id),
    .win_vec    (win_vec),
    .promo_q    (promo_q),
    .xm_shut    (xm_shut)
);

// File: tb/irq_resolver_bench.sv
`timescale 1ns/1ps
module irq_resolver_bench;

    localparam int NMSK = 19;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            illop_req, swi_req, xpin_req, xmask_set;
    logic [NMSK-1:0] msk_req, msk_en;
    logic            gmask, prio_we;
    logic [4:0]      prio_wdata;
    logic            irq_out;
    logic [4:0]      win_id;
    logic [15:0]     win_vec;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        v;
        logic [4:0]  id;
        logic [15:0] vec;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    irq_resolver u_irq_resolver (
        .clk(clk), .rst_n(rst_n), .illop_req(illop_req), .swi_req(swi_req),
        .xpin_req(xpin_req), .xmask_set(xmask_set), .msk_req(msk_req),
        .msk_en(msk_en), .gmask(gmask), .prio_we(prio_we), .prio_wdata(prio_wdata),
        .irq_out(irq_out), .win_id(win_id), .win_vec(win_vec)
    );

    // R11 vector rule, taken from the requirement text
    function automatic logic [15:0] vec_for(input logic [4:0] id);
        int m;
        if (id < 5'd3) return 16'hFFF8 - 16'(2 * id);
        m = int'(id) - 3;
        if (m >= 14) return 16'hFFD6;
        return 16'hFFF2 - 16'(2 * m);
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (irq_out !== e.v || win_id !== e.id || win_vec !== e.vec) begin
            errors++;
            $display("FAIL %s: got irq=%0b id=%0d vec=%h, expected irq=%0b id=%0d vec=%h",
                     e.tag, irq_out, win_id, win_vec, e.v, e.id, e.vec);
        end
    endtask

    // monitor: pops one expectation per edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    task automatic quiet();
        illop_req = 0; swi_req = 0; xpin_req = 0; xmask_set = 0;
        msk_req = '0; msk_en = '0; gmask = 0; prio_we = 0; prio_wdata = '0;
    endtask

    // driver: the inputs set by the caller are sampled at the next rising edge
    task automatic cyc(input logic v, input logic [4:0] id, input string tag);
        exp_t e;
        e.v = v;
        e.id = v ? id : 5'd0;
        e.vec = v ? vec_for(id) : 16'h0;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    function automatic logic [4:0] mid(input int k);
        return 5'(k + 3);
    endfunction

    task automatic reset_check(input string tag);
        exp_t e;
        rst_n = 0;
        repeat (3) @(negedge clk);
        e.v = 0; e.id = 0; e.vec = 0; e.tag = tag;
        compare(e);
        rst_n = 1;
    endtask

    initial begin
        quiet();
        @(negedge clk);
        reset_check("R1 reset state");

        cyc(0, 0, "R2 idle with no requests");

        illop_req = 1; swi_req = 1; xpin_req = 1; msk_req[0] = 1;
        cyc(1, 0, "R3 illegal trap on top");
        illop_req = 0;
        cyc(1, 1, "R3 software trap over pin");
        swi_req = 0; gmask = 1;
        cyc(1, 2, "R3 pin wins with gmask set");
        quiet();

        msk_req[3] = 1; msk_en[3] = 1; gmask = 1;
        cyc(0, 0, "R5 maskable blocked by gmask");
        quiet();

        msk_req[0] = 1;
        cyc(1, mid(0), "R6 external pin needs no enable, R10 id");
        quiet();

        msk_req[5] = 1;
        cyc(0, 0, "R6 source without enable ignored");
        msk_en[5] = 1;
        cyc(1, mid(5), "R6 enabled source served, R11 vector");
        quiet();

        msk_req[2] = 1; msk_req[7] = 1; msk_en = '1;
        cyc(1, mid(2), "R7 lower index wins");
        quiet();

        msk_req[16] = 1; msk_en[16] = 1;
        cyc(1, mid(16), "R11 shared vector, source 16");
        msk_req = '0; msk_req[18] = 1; msk_en[18] = 1;
        cyc(1, mid(18), "R11 shared vector, source 18");
        msk_req = '0; msk_req[13] = 1; msk_en[13] = 1;
        cyc(1, mid(13), "R11 last own vector");
        quiet();

        // write with gmask clear: ignored
        prio_we = 1; prio_wdata = 5'd7;
        cyc(0, 0, "R9 write while unmasked");
        quiet();
        msk_req[2] = 1; msk_req[7] = 1; msk_en = '1;
        cyc(1, mid(2), "R9 unmasked write had no effect");
        quiet();

        // accepted write
        gmask = 1; prio_we = 1; prio_wdata = 5'd7;
        cyc(0, 0, "R9 write while masked");
        quiet();
        msk_req[2] = 1; msk_req[7] = 1; msk_en = '1;
        cyc(1, mid(7), "R8 promoted source wins");
        msk_en[7] = 0;
        cyc(1, mid(2), "R8 disabled promoted source falls back");
        quiet();

        // out-of-range index ignored
        gmask = 1; prio_we = 1; prio_wdata = 5'd25;
        cyc(0, 0, "R9 out-of-range write");
        quiet();
        msk_req[0] = 1; msk_req[7] = 1; msk_en = '1;
        cyc(1, mid(7), "R9 promotion kept after bad write");
        quiet();

        // write takes effect from the next cycle
        gmask = 1; prio_we = 1; prio_wdata = 5'd2;
        cyc(0, 0, "R9 write to 2");
        gmask = 0; prio_we = 0; msk_req[2] = 1; msk_req[7] = 1; msk_en = '1;
        cyc(1, mid(2), "R9 new promotion in force");
        quiet();

        // pin mask
        xmask_set = 1; xpin_req = 1;
        cyc(1, 2, "R4 pin served in the set cycle");
        xmask_set = 0;
        cyc(0, 0, "R4 pin blocked after set");
        msk_req[1] = 1; msk_en[1] = 1;
        cyc(1, mid(1), "R4 maskable served while pin blocked");
        quiet();
        xpin_req = 1;
        cyc(0, 0, "R4 pin still blocked");
        quiet();

        reset_check("R1 reset state again");
        xpin_req = 1;
        cyc(1, 2, "R1 reset reopens pin mask");
        quiet();
        msk_req[0] = 1; msk_req[7] = 1; msk_en = '1;
        cyc(1, mid(0), "R1 promotion back to source 0");
        quiet();
        cyc(0, 0, "R2 return to idle");
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule